// File: doc/BRIEF.md
# Input Sample Error Detector

This block checks a parallel sample port against a programmed four-word test pattern. Incoming words belong to a repeating frame of four lane positions: I0, Q0, I1 and Q1. A frame strobe marks where each frame starts. Every accepted word is compared with the expected value for its lane. The results are kept as sticky and live status flags, a per-bit error mask for each lane, and an interrupt line gated by enable bits.

The pattern, the control bits and the interrupt enables are set through a small byte-wide register write port. A bring-up flow works like this:
1. Load the four expected words and turn comparison on.
2. Stream the pattern while toggling the strobe at each I0.
3. Read the masks to find which data bits failed.

An optional self-clearing mode lets the fail indication and the masks recover after a clean run. This gives a live view of link health rather than a log of everything that has failed.

Top module: `smpl_err_mon`

## Requirements
- R1: The expected words are written one byte per write, low byte first. Address 2+2k holds bits 7:0 of lane k and address 3+2k holds bits 15:8, with lane order 0=I0, 1=Q0, 2=I1, 3=Q1. A later write to one byte changes only that byte of the expected word.
- R2: A sample taken while `smp_frame` is high, when the previous accepted sample had it low, is compared as lane 0. Otherwise the lane is one more than the previous accepted sample's lane, modulo 4. This lets the position free-run between strobes and realign mid-frame.
- R3: Lane k's mask (bits 16k+15:16k of `err_mask`) ORs in captured XOR expected at the clock edge that accepts the sample. Mismatched bits stay set until they are cleared.
- R4: `err_sticky` sets at the edge that accepts any mismatching sample. It stays set until a clear command; no clean run removes it.
- R5: `cmp_pass` shows whether the most recently accepted sample matched. `cmp_fail` sets on every mismatch.
- R6: With the autoclear bit (control bit 1) set, the eighth consecutive clean comparison clears `cmp_fail` and all masks. With the bit clear, both are kept.
- R7: A mismatch restarts the consecutive-clean count from zero.
- R8: With the enable bit (control bit 0) low, samples are ignored. Flags, masks and the lane position stay frozen, and the next sample after re-enabling takes the lane that follows the last accepted one.
- R9: Writing control with bit 2 set clears `err_sticky`, `cmp_fail` and all masks at that edge. If the same edge also accepts a mismatch, that mismatch shows one edge later in `err_sticky`, `cmp_fail` and its mask.
- R10: `irq` is the OR of the flags whose enable bit at address 1 is set: bit 0 for pass, bit 1 for fail, bit 2 for sticky error.
- R11: After reset, all flags, all masks and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Register write byte |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_frame | input | 1 | Frame strobe, high over I0 and Q0 |
| smp_data | input | WORD_W | Captured sample word |
| err_sticky | output | 1 | Sticky mismatch flag |
| cmp_pass | output | 1 | Last comparison was clean |
| cmp_fail | output | 1 | Mismatch seen and not yet cleared |
| err_mask | output | LANES*WORD_W | Accumulated per-bit error masks, lane k at bits WORD_W*k upward |
| irq | output | 1 | Interrupt request |

## Verification
A register write acts at the edge that samples it. The flags and masks for an accepted sample change at that same edge. With the default variant, `irq` follows the flags within that cycle. The only result due later is the mismatch that collides with a clear: it appears exactly one edge after the clear. The bench therefore drives every input at the falling edge and checks 2 ns after the next rising edge. For the collision it checks twice: once right after the clearing edge, where the state must read zero, and once after one further idle edge, where the held mismatch must be visible.

// File: rtl/sme_pkg.sv
package sme_pkg;
   // register addresses
   localparam int unsigned CTRL_ADDR     = 0;
   localparam int unsigned IEN_ADDR      = 1;
   localparam int unsigned PAT_BASE      = 2;
   // control bits
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_AUTO_BIT = 1;
   localparam int unsigned CTRL_CLR_BIT  = 2;

   typedef struct packed {
      logic autoclr;
      logic enable;
   } ctrl_t;

   // bit order matches the interrupt enable register
   typedef struct packed {
      logic err;
      logic fail;
      logic pass;
   } flags_t;
endpackage

// File: rtl/sme_cfg_regs.sv
module sme_cfg_regs
   import sme_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned LANES  = 4,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [7:0]                wdata,
   output ctrl_t                     ctrl_o,
   output logic [2:0]                ien_o,
   output logic                      clr_o,
   output logic [LANES*WORD_W-1:0]   pat_o
);
   localparam int unsigned BPW   = WORD_W / 8;
   localparam int unsigned NBYTE = LANES * BPW;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);

   logic  wr_ctrl;
   logic  wr_ien;
   ctrl_t ctrl_q;
   logic [2:0] ien_q;

   assign wr_ctrl = we && (addr == A_CTRL);
   assign wr_ien  = we && (addr == A_IEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.enable  <= wdata[CTRL_EN_BIT];
         ctrl_q.autoclr <= wdata[CTRL_AUTO_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (wr_ien) begin
         ien_q <= wdata[2:0];
      end
   end

   // clear is a one-cycle command, never stored
   assign clr_o  = wr_ctrl && wdata[CTRL_CLR_BIT];
   assign ctrl_o = ctrl_q;
   assign ien_o  = ien_q;

   // one byte register per pattern byte; byte b lives at bits 8b+7:8b
   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(PAT_BASE + b);
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (we && (addr == A_BYTE)) begin
            byte_q <= wdata;
         end
      end
      assign pat_o[b*8 +: 8] = byte_q;
   end
endmodule

// File: rtl/sme_frame_align.sv
module sme_frame_align #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             valid,
   input  logic             frame,
   output logic             hit_o,
   output logic [LANES-1:0] sel_o
);
   localparam int unsigned SLOT_W = $clog2(LANES);

   logic [SLOT_W-1:0] pos_q;
   logic [SLOT_W-1:0] slot;
   logic              fprev_q;
   logic              rise;

   assign hit_o = en && valid;
   // a new strobe pulls the position back to the first lane
   assign rise  = frame && !fprev_q;
   assign slot  = rise ? '0 : pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         fprev_q <= 1'b0;
      end else if (hit_o) begin
         fprev_q <= frame;
         pos_q   <= slot + SLOT_W'(1);
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_sel
      assign sel_o[l] = hit_o && (slot == SLOT_W'(l));
   end
endmodule

// File: rtl/sme_lane_cmp.sv
module sme_lane_cmp #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        sel,
   input  logic [WORD_W-1:0]       data,
   input  logic [LANES*WORD_W-1:0] pat,
   input  logic                    clr,
   input  logic                    wipe,
   output logic [LANES*WORD_W-1:0] mask_o,
   output logic                    bad_o,
   output logic                    carry_o
);
   logic [LANES-1:0] lane_bad;
   logic [LANES-1:0] lane_carry;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WORD_W-1:0] diff;
      logic [WORD_W-1:0] sel_diff;
      logic [WORD_W-1:0] carry_q;
      logic [WORD_W-1:0] mask_q;

      assign diff          = data ^ pat[l*WORD_W +: WORD_W];
      assign sel_diff      = sel[l] ? diff : '0;
      assign lane_bad[l]   = |sel_diff;
      assign lane_carry[l] = |carry_q;

      // a mismatch that meets a clear is held for one cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            carry_q <= '0;
         end else begin
            carry_q <= clr ? sel_diff : '0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= '0;
         end else if (clr) begin
            mask_q <= '0;
         end else begin
            mask_q <= (wipe ? '0 : mask_q) | carry_q | sel_diff;
         end
      end

      assign mask_o[l*WORD_W +: WORD_W] = mask_q;
   end

   assign bad_o   = |lane_bad;
   assign carry_o = |lane_carry;
endmodule

// File: rtl/sme_status.sv
module sme_status
   import sme_pkg::*;
#(
   parameter int unsigned CLEAN_RUN = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   hit,
   input  logic   bad,
   input  logic   carry,
   input  logic   clr,
   input  logic   autoclr,
   output flags_t flags_o,
   output logic   wipe_o
);
   localparam int unsigned CNT_W = $clog2(CLEAN_RUN + 1);
   localparam logic [CNT_W-1:0] RUN_TOP  = CNT_W'(CLEAN_RUN);
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(CLEAN_RUN - 1);

   logic [CNT_W-1:0] run_q;
   flags_t           fl_q;
   logic             clean;
   logic             any_err;

   assign clean   = hit && !bad;
   assign any_err = bad || carry;
   // the clean comparison that completes the run triggers the wipe
   assign wipe_o  = autoclr && clean && !carry && (run_q == RUN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q  <= '0;
         run_q <= '0;
      end else begin
         if (clr) begin
            fl_q.err  <= 1'b0;
            fl_q.fail <= 1'b0;
            run_q     <= '0;
         end else begin
            if (any_err) begin
               fl_q.err  <= 1'b1;
               fl_q.fail <= 1'b1;
            end else if (wipe_o) begin
               fl_q.fail <= 1'b0;
            end
            if (any_err) begin
               run_q <= '0;
            end else if (clean && (run_q != RUN_TOP)) begin
               run_q <= run_q + CNT_W'(1);
            end
         end
         if (hit) begin
            fl_q.pass <= !bad;
         end
      end
   end

   assign flags_o = fl_q;
endmodule

// File: rtl/smpl_err_mon.sv
module smpl_err_mon
   import sme_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned LANES     = 4,
   parameter int unsigned CLEAN_RUN = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [ADDR_W-1:0]       cfg_addr,
   input  logic [7:0]              cfg_wdata,
   input  logic                    smp_valid,
   input  logic                    smp_frame,
   input  logic [WORD_W-1:0]       smp_data,
   output logic                    err_sticky,
   output logic                    cmp_pass,
   output logic                    cmp_fail,
   output logic [LANES*WORD_W-1:0] err_mask,
   output logic                    irq
);
   localparam int unsigned NBYTE = LANES * (WORD_W / 8);

   if (WORD_W == 0 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("WORD_W must be a nonzero multiple of 8");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (CLEAN_RUN < 1) begin : g_bad_run
      $error("CLEAN_RUN must be at least 1");
   end
   if (PAT_BASE + NBYTE > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the pattern bytes");
   end

   ctrl_t                   ctrl_w;
   logic [2:0]              ien_w;
   logic                    clr_w;
   logic [LANES*WORD_W-1:0] pat_w;
   logic                    hit_w;
   logic [LANES-1:0]        sel_w;
   logic                    bad_w;
   logic                    carry_w;
   logic                    wipe_w;
   logic                    en_w;
   flags_t                  flags_w;
   logic                    irq_next;

   sme_cfg_regs #(.WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .ctrl_o (ctrl_w),
      .ien_o  (ien_w),
      .clr_o  (clr_w),
      .pat_o  (pat_w)
   );

   assign en_w = ctrl_w.enable;

   sme_frame_align #(.LANES(LANES)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_w),
      .valid (smp_valid),
      .frame (smp_frame),
      .hit_o (hit_w),
      .sel_o (sel_w)
   );

   sme_lane_cmp #(.WORD_W(WORD_W), .LANES(LANES)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_w),
      .data    (smp_data),
      .pat     (pat_w),
      .clr     (clr_w),
      .wipe    (wipe_w),
      .mask_o  (err_mask),
      .bad_o   (bad_w),
      .carry_o (carry_w)
   );

   sme_status #(.CLEAN_RUN(CLEAN_RUN)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_w),
      .bad     (bad_w),
      .carry   (carry_w),
      .clr     (clr_w),
      .autoclr (ctrl_w.autoclr),
      .flags_o (flags_w),
      .wipe_o  (wipe_w)
   );

   assign err_sticky = flags_w.err;
   assign cmp_fail   = flags_w.fail;
   assign cmp_pass   = flags_w.pass;
   assign irq_next   = |(ien_w & flags_w);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= irq_next;
         end
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_next;
   end
endmodule

// File: rtl/sme_chk.sv
module sme_chk #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned LANES  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr_w,
   input logic                    en_w,
   input logic                    hit_w,
   input logic                    bad_w,
   input logic                    carry_w,
   input logic [LANES-1:0]        sel_w,
   input logic [2:0]              ien_w,
   input logic                    err_sticky,
   input logic                    cmp_pass,
   input logic                    cmp_fail,
   input logic [LANES*WORD_W-1:0] err_mask,
   input logic                    irq
);
   AST_ONE_LANE_PER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w |-> $countones(sel_w) == 1); // R2

   AST_MASK_NEEDS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_mask) |-> err_sticky); // R3

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky && !clr_w |=> err_sticky); // R4

   AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w && bad_w && !clr_w |=> cmp_fail && err_sticky && !cmp_pass); // R5

   AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w && !bad_w |=> cmp_pass); // R5

   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_w && !clr_w && !carry_w |=> $stable(err_mask) && $stable(err_sticky) && $stable(cmp_fail)); // R8

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> !err_sticky && !cmp_fail && (err_mask == '0)); // R9

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_w == 3'b000) && ($past(ien_w) == 3'b000) |-> !irq); // R10
endmodule

bind smpl_err_mon sme_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_w      (clr_w),
   .en_w       (en_w),
   .hit_w      (hit_w),
   .bad_w      (bad_w),
   .carry_w    (carry_w),
   .sel_w      (sel_w),
   .ien_w      (ien_w),
   .err_sticky (err_sticky),
   .cmp_pass   (cmp_pass),
   .cmp_fail   (cmp_fail),
   .err_mask   (err_mask),
   .irq        (irq)
);

// File: tb/sim_smpl_err_mon.sv
module sim_smpl_err_mon;
   localparam int W = 16;
   localparam int L = 4;

   // row: bit 16 frame strobe, bits 15:0 sample word
   localparam logic [16:0] VEC [13] = '{
      17'h1_A5C3, 17'h1_5A3C, 17'h0_F00F, 17'h0_0FF0,  // aligned clean frame (R1)
      17'h0_A5C3, 17'h0_5A3D, 17'h0_F00F, 17'h0_8FF0,  // free-run, two bad words
      17'h0_A5C3, 17'h1_A5C3, 17'h1_5A3C, 17'h0_F00E,  // mid-frame realign (R2)
      17'h0_0FF0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            cfg_we = 1'b0;
   logic [3:0]      cfg_addr = '0;
   logic [7:0]      cfg_wdata = '0;
   logic            smp_valid = 1'b0;
   logic            smp_frame = 1'b0;
   logic [W-1:0]    smp_data = '0;
   logic            err_sticky, cmp_pass, cmp_fail, irq;
   logic [L*W-1:0]  err_mask;

   smpl_err_mon u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_frame(smp_frame),
      .smp_data(smp_data), .err_sticky(err_sticky), .cmp_pass(cmp_pass),
      .cmp_fail(cmp_fail), .err_mask(err_mask), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] pat [4];
   logic [15:0] m_mask [4];
   logic        m_err = 0, m_pass = 0, m_fail = 0, m_en = 0, m_auto = 0, m_fprev = 0;
   logic [2:0]  m_ien = 0;
   int          m_pos = 0, m_run = 0;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic m_irq;
      m_irq = (m_ien[0] & m_pass) | (m_ien[1] & m_fail) | (m_ien[2] & m_err);
      check({tag, " err_sticky"}, 32'(err_sticky), 32'(m_err));
      check({tag, " cmp_pass"},   32'(cmp_pass),   32'(m_pass));
      check({tag, " cmp_fail"},   32'(cmp_fail),   32'(m_fail));
      for (int k = 0; k < L; k++)
         check($sformatf("%s mask lane %0d", tag, k), 32'(err_mask[k*W +: W]), 32'(m_mask[k]));
      check({tag, " irq"}, 32'(irq), 32'(m_irq));
   endtask

   function automatic int next_lane(input logic f);
      return (f && !m_fprev) ? 0 : m_pos;
   endfunction

   task automatic model_clear();
      m_err = 0; m_fail = 0; m_run = 0;
      for (int k = 0; k < L; k++) m_mask[k] = '0;
   endtask

   task automatic model_apply(input logic f, input logic [15:0] d);
      int lane;
      logic [15:0] diff;
      if (!m_en) return;
      lane = next_lane(f);
      m_fprev = f;
      m_pos = (lane + 1) % L;
      diff = d ^ pat[lane];
      if (diff != 0) begin
         m_err = 1; m_fail = 1; m_pass = 0; m_run = 0;
         m_mask[lane] = m_mask[lane] | diff;
      end else begin
         m_pass = 1;
         if (m_auto && m_run == 7) begin
            m_fail = 0;
            for (int k = 0; k < L; k++) m_mask[k] = '0;
         end
         if (m_run < 8) m_run++;
      end
   endtask

   task automatic cfg_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; smp_valid = 1'b0;
      @(posedge clk); #2;
      cfg_we = 1'b0;
   endtask

   task automatic set_ctrl(input logic en, input logic au, input logic clr);
      cfg_wr(4'd0, {5'b0, clr, au, en});
      m_en = en; m_auto = au;
      if (clr) model_clear();
   endtask

   task automatic set_ien(input logic [2:0] v);
      cfg_wr(4'd1, {5'b0, v});
      m_ien = v;
   endtask

   task automatic send_raw(input logic f, input logic [15:0] d);
      @(negedge clk);
      smp_valid = 1'b1; smp_frame = f; smp_data = d;
      @(posedge clk); #2;
      smp_valid = 1'b0;
      model_apply(f, d);
   endtask

   task automatic send(input logic f, input logic [15:0] flip);
      send_raw(f, pat[next_lane(f)] ^ flip);
   endtask

   task automatic tick();
      @(negedge clk);
      @(posedge clk); #2;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      pat[0] = 16'hA5C3; pat[1] = 16'h5A3C; pat[2] = 16'hF00F; pat[3] = 16'h0FF0;
      for (int k = 0; k < L; k++) m_mask[k] = '0;

      // R11: state during and after reset
      repeat (3) @(posedge clk);
      #2 check_all("R11");
      @(negedge clk) rst_n = 1'b1;
      tick();
      check_all("R11");

      // R1: pattern bytes, low then high
      for (int k = 0; k < L; k++) begin
         cfg_wr(4'(2 + 2*k), pat[k][7:0]);
         cfg_wr(4'(3 + 2*k), pat[k][15:8]);
      end
      set_ctrl(1, 0, 0);

      // vector table: R2 R3 R4 R5
      for (int i = 0; i < 13; i++) begin
         send_raw(VEC[i][16], VEC[i][15:0]);
         check_all($sformatf("R3 R4 R5 row %0d", i));
         if (i == 9) check("R2 realign to lane 0", 32'(cmp_pass), 32'd1);
      end
      check("R3 lane1 bit0 kept", 32'(err_mask[16 +: 16]), 32'h0001);
      check("R3 lane3 bit15 kept", 32'(err_mask[48 +: 16]), 32'h8000);

      // R1: rewrite only Q1 high byte
      cfg_wr(4'd9, 8'h1F);
      pat[3][15:8] = 8'h1F;
      send(1, 0); send(1, 0); send(0, 0);
      send_raw(0, 16'h0FF0);
      check("R1 single byte reload", 32'(err_mask[48 +: 16]), 32'h9000);
      check_all("R1");
      cfg_wr(4'd9, 8'h0F);
      pat[3][15:8] = 8'h0F;

      // R9: plain clear
      set_ctrl(1, 0, 1);
      check_all("R9 clear");
      check("R9 sticky cleared", 32'(err_sticky), 32'd0);

      // R9: clear colliding with a mismatch on lane 0
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h05;
      smp_valid = 1'b1; smp_frame = 1'b1; smp_data = pat[0] ^ 16'h0100;
      @(posedge clk); #2;
      cfg_we = 1'b0; smp_valid = 1'b0;
      model_apply(1, pat[0] ^ 16'h0100);
      model_clear();
      check_all("R9 collide edge");
      tick();
      m_err = 1; m_fail = 1; m_mask[0] = 16'h0100;
      check_all("R9 collide next");
      check("R9 held mismatch", 32'(err_mask[0 +: 16]), 32'h0100);
      send(1, 0); send(0, 0); send(0, 0);

      // R6: autoclear after eight clean comparisons
      set_ctrl(1, 1, 1);
      send(1, 16'h0002);
      send(1, 0);
      for (int j = 0; j < 6; j++) send(0, 0);
      check("R6 fail kept after 7 clean", 32'(cmp_fail), 32'd1);
      check_all("R6 seven");
      send(0, 0);
      check("R6 fail cleared", 32'(cmp_fail), 32'd0);
      check("R6 masks cleared", 32'(|err_mask), 32'd0);
      check("R6 sticky kept", 32'(err_sticky), 32'd1);
      check_all("R6 eight");

      // R7: a mismatch restarts the run
      send(0, 16'h0400);
      for (int j = 0; j < 7; j++) send(0, 0);
      send(0, 16'h0010);
      for (int j = 0; j < 7; j++) send(0, 0);
      check("R7 run restarted", 32'(cmp_fail), 32'd1);
      check_all("R7 seven");
      send(0, 0);
      check("R7 clears on eighth", 32'(cmp_fail), 32'd0);
      check_all("R7 eight");

      // R8: disabled input is ignored and position is frozen
      send(0, 16'h0020);
      set_ctrl(0, 1, 0);
      for (int j = 0; j < 3; j++) send_raw(j[0], 16'hFFFF);
      check_all("R8 frozen");
      set_ctrl(1, 1, 0);
      send(0, 0);
      check("R8 position resumes", 32'(cmp_pass), 32'd1);
      check_all("R8 resumed");

      // R10: interrupt gating
      set_ien(3'b100);
      check("R10 sticky enabled", 32'(irq), 32'd1);
      set_ien(3'b000);
      check("R10 none enabled", 32'(irq), 32'd0);
      set_ien(3'b001);
      check("R10 pass enabled", 32'(irq), 32'd1);
      d = 16'h0040;
      send(0, d);
      check("R10 pass dropped", 32'(irq), 32'd0);
      set_ien(3'b010);
      check("R10 fail enabled", 32'(irq), 32'd1);
      check_all("R10");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule